// File: doc/BRIEF.md
# Multiplexed Converter Channel-Switch Sequencer

This block lets one serially programmed sigma-delta converter serve four differential inputs through an external analog multiplexer. For each channel it keeps a setup image of four 24-bit words: a control word that sets gain and filter, an offset coefficient, a positive full-scale coefficient and a negative full-scale coefficient. A channel change takes place in a fixed order. The converter is first held in standby by pulling the active-low sync line. The 2-bit multiplexer address then changes. The stored image is shifted out as one 128-bit serial burst, and sync is released. The first conversions after release are still settling, so they are dropped, and the first settled result is presented tagged with its channel.

A calibration pass steps through all four channels. On each one it takes the three settled conversions that follow the settling window as the offset, positive full-scale and negative full-scale coefficients, and writes them into that channel's image. It then switches back to the channel that was selected before the pass, so the new coefficients are loaded into the converter. Conversion results and calibration read-backs arrive as a 24-bit word marked by a one-cycle data-ready pulse. Control words are loaded through a simple write port.

Top module: `mux_adc_sequencer`

## Requirements
- R1: `mux_addr` carries the selected input as a 2-bit code: 00 selects input 1, 01 input 2, 10 input 3 and 11 input 4. A switch request with `sw_ch` = k drives `mux_addr` to k, and the result that follows carries `res_ch` = k.
- R2: `sync_n` goes low at least one cycle before `mux_addr` changes. It stays low while `ser_cs_n` is low, and it returns high only in the cycle after the burst ends.
- R3: A burst is 128 bits sent most significant bit first while `ser_cs_n` is low. It is made of four groups, each an 8-bit instruction followed by a 24-bit word. The groups go in this order: C0 with the control word, C1 with the offset coefficient, C2 with the positive full-scale coefficient, C3 with the negative full-scale coefficient (hex, default parameters).
- R4: Each channel keeps its own four words. A write with `cfg_we` high stores `cfg_data` into word `cfg_sel` of channel `cfg_ch` (0 control, 1 offset, 2 positive full-scale, 3 negative full-scale). Every switch to a channel sends that channel's current words.
- R5: After `sync_n` rises, the first three `adc_drdy` pulses are dropped. On the fourth, `adc_data` is presented on `res_data` with `res_valid` high for exactly one cycle.
- R6: `busy` is high from the cycle after a request is accepted until the cycle in which `res_valid` is high, where it is low.
- R7: A `cal_req` runs channels 0 to 3 in order. For each channel it sends a burst, drops three conversions and stores the next three as offset, positive full-scale and negative full-scale. It then switches back to the channel that was selected before the pass, sending that channel's updated words, and reports one result.
- R8: `ser_sclk` is high whenever `ser_cs_n` is high. During a burst each half period lasts `sclk_half` clock cycles. `ser_sdo` changes only when `ser_sclk` falls, and `ser_cs_n` stays low for exactly 256 × `sclk_half` cycles.
- R9: A request that arrives while a sequence is running is held and served after the sequence ends. Among held switch requests only the newest target is served, and a held calibration request runs before a held switch.
- R10: `adc_drdy` pulses while no sequence is running produce no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | One-cycle channel switch request |
| sw_ch | input | 2 | Target channel of the switch |
| cal_req | input | 1 | One-cycle calibration pass request |
| cfg_we | input | 1 | Setup word write enable |
| cfg_ch | input | 2 | Channel of the setup write |
| cfg_sel | input | 2 | Word index of the setup write |
| cfg_data | input | 24 | Setup word value |
| sclk_half | input | 8 | Serial clock half period in clock cycles |
| adc_drdy | input | 1 | Conversion-complete pulse from the converter |
| adc_data | input | 24 | Conversion or read-back word |
| sync_n | output | 1 | Active-low converter standby |
| mux_addr | output | 2 | Analog multiplexer address |
| ser_sclk | output | 1 | Serial clock, idles high |
| ser_sdo | output | 1 | Serial data out |
| ser_cs_n | output | 1 | Active-low serial chip select |
| busy | output | 1 | Sequence in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Result word |
| res_ch | output | 2 | Channel the result belongs to |

## Verification
Switches are made to different channels, and each channel holds distinct words. A burst sent from the wrong channel, with its words in the wrong order, or with the instruction bytes misplaced therefore shows up as a mismatch in the captured 128 bits. Two serial clock settings, 8 and 2 cycles per half period, separate a correct divider and bit count from an off-by-one in either. The converter model tags every conversion with its index since sync release, so reporting the third or fifth conversion in place of the fourth is caught. Back-to-back requests during a running sequence, a calibration pass, and conversions that keep arriving while idle check the held-request rules, the placement of the captured coefficients and the suppression of unwanted results.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_ADDR,
      ST_BURST,
      ST_SETTLE
   } seq_st_e;

   localparam int unsigned SETUP_WORDS = 4;
endpackage

// File: rtl/mxs_setup_store.sv
module mxs_setup_store #(
   parameter int unsigned N_CH    = 4,
   parameter int unsigned N_WORDS = 4,
   parameter int unsigned WORD_W  = 24,
   localparam int unsigned CH_W   = $clog2(N_CH),
   localparam int unsigned SEL_W  = $clog2(N_WORDS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [CH_W-1:0]                   cfg_ch,
   input  logic [SEL_W-1:0]                  cfg_sel,
   input  logic [WORD_W-1:0]                 cfg_data,
   input  logic                              cap_we,
   input  logic [CH_W-1:0]                   cap_ch,
   input  logic [SEL_W-1:0]                  cap_sel,
   input  logic [WORD_W-1:0]                 cap_data,
   input  logic [CH_W-1:0]                   rd_ch,
   output logic [N_WORDS-1:0][WORD_W-1:0]    rd_img
);
   logic [WORD_W-1:0] mem [N_CH][N_WORDS];

   // captured calibration words win over a host write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < N_CH; c++)
            for (int w = 0; w < N_WORDS; w++)
               mem[c][w] <= '0;
      end else if (cap_we) begin
         mem[cap_ch][cap_sel] <= cap_data;
      end else if (cfg_we) begin
         mem[cfg_ch][cfg_sel] <= cfg_data;
      end
   end

   always_comb begin
      for (int w = 0; w < N_WORDS; w++)
         rd_img[w] = mem[rd_ch][w];
   end
endmodule

// File: rtl/mxs_serializer.sv
module mxs_serializer #(
   parameter int unsigned BURST_W = 128,
   parameter int unsigned DIV_W   = 8,
   localparam int unsigned CNT_W  = $clog2(BURST_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BURST_W-1:0] load,
   input  logic [DIV_W-1:0]   half,
   output logic               sclk,
   output logic               sdo,
   output logic               cs_n,
   output logic               done
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BURST_W - 1);

   logic [BURST_W-1:0] shreg;
   logic [CNT_W-1:0]   bitcnt;
   logic [DIV_W-1:0]   ph;
   logic [DIV_W-1:0]   ph_lim;
   logic               active;

   assign ph_lim = (half == '0) ? '0 : half - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
         ph     <= '0;
         active <= 1'b0;
         sclk   <= 1'b1;
         sdo    <= 1'b0;
         cs_n   <= 1'b1;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active <= 1'b1;
            cs_n   <= 1'b0;
            shreg  <= load;
            bitcnt <= '0;
            ph     <= '0;
            sclk   <= 1'b1;
         end else if (active) begin
            if (ph == ph_lim) begin
               ph   <= '0;
               sclk <= ~sclk;
               if (sclk) begin
                  // falling edge: present next bit
                  sdo   <= shreg[BURST_W-1];
                  shreg <= shreg << 1;
               end else begin
                  // rising edge: receiver samples
                  bitcnt <= bitcnt + CNT_W'(1);
                  if (bitcnt == LAST_BIT) begin
                     active <= 1'b0;
                     cs_n   <= 1'b1;
                     done   <= 1'b1;
                  end
               end
            end else begin
               ph <= ph + DIV_W'(1);
            end
         end
      end
   end

   p_sclk_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);
   p_sdo_stable_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(sdo));
endmodule

// File: rtl/mux_adc_sequencer.sv
module mux_adc_sequencer
   import mxs_pkg::*;
#(
   parameter int unsigned N_CH       = 4,
   parameter int unsigned WORD_W     = 24,
   parameter int unsigned INSTR_W    = 8,
   parameter int unsigned SETTLE_N   = 3,
   parameter int unsigned DIV_W      = 8,
   parameter logic [7:0]  INSTR_CTRL = 8'hC0,
   parameter logic [7:0]  INSTR_OFF  = 8'hC1,
   parameter logic [7:0]  INSTR_PFS  = 8'hC2,
   parameter logic [7:0]  INSTR_NFS  = 8'hC3,
   localparam int unsigned CH_W      = $clog2(N_CH),
   localparam int unsigned N_WORDS   = SETUP_WORDS,
   localparam int unsigned SEL_W     = $clog2(N_WORDS),
   localparam int unsigned GRP_W     = INSTR_W + WORD_W,
   localparam int unsigned BURST_W   = N_WORDS * GRP_W,
   localparam int unsigned SCNT_W    = $clog2(SETTLE_N + N_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_req,
   input  logic [CH_W-1:0]    sw_ch,
   input  logic               cal_req,
   input  logic               cfg_we,
   input  logic [CH_W-1:0]    cfg_ch,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [WORD_W-1:0]  cfg_data,
   input  logic [DIV_W-1:0]   sclk_half,
   input  logic               adc_drdy,
   input  logic [WORD_W-1:0]  adc_data,
   output logic               sync_n,
   output logic [CH_W-1:0]    mux_addr,
   output logic               ser_sclk,
   output logic               ser_sdo,
   output logic               ser_cs_n,
   output logic               busy,
   output logic               res_valid,
   output logic [WORD_W-1:0]  res_data,
   output logic [CH_W-1:0]    res_ch
);
   localparam logic [N_WORDS-1:0][INSTR_W-1:0] INSTR =
      {INSTR_W'(INSTR_NFS), INSTR_W'(INSTR_PFS), INSTR_W'(INSTR_OFF), INSTR_W'(INSTR_CTRL)};
   localparam logic [SCNT_W-1:0] LAST_CAP = SCNT_W'(SETTLE_N + N_WORDS - 2);

   generate
      if (N_CH < 2 || (1 << CH_W) != N_CH) begin : g_bad_nch
         $error("N_CH must be a power of two of at least 2");
      end
      if (SETTLE_N < 1) begin : g_bad_settle
         $error("SETTLE_N must be at least 1");
      end
      if (INSTR_W > 8) begin : g_bad_instr
         $error("INSTR_W may not exceed the instruction parameter width");
      end
   endgenerate

   seq_st_e                      state;
   logic [CH_W-1:0]              tgt, ret_ch, pend_ch;
   logic                         pend_sw, pend_cal, cal_mode;
   logic [SCNT_W-1:0]            scnt;
   logic [N_WORDS-1:0][WORD_W-1:0] img;
   logic [BURST_W-1:0]           burst;
   logic                         ser_done, cap_we;
   logic [SEL_W-1:0]             cap_sel;

   // burst image: group 0 (control) leaves first
   for (genvar g = 0; g < N_WORDS; g++) begin : g_pack
      assign burst[BURST_W-1-g*GRP_W -: GRP_W] = {INSTR[g], img[g]};
   end

   assign cap_we  = (state == ST_SETTLE) && cal_mode && adc_drdy &&
                    (scnt >= SCNT_W'(SETTLE_N));
   assign cap_sel = SEL_W'(scnt - SCNT_W'(SETTLE_N) + SCNT_W'(1));
   assign busy    = (state != ST_IDLE);

   mxs_setup_store #(.N_CH(N_CH), .N_WORDS(N_WORDS), .WORD_W(WORD_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .cap_we(cap_we), .cap_ch(tgt), .cap_sel(cap_sel), .cap_data(adc_data),
      .rd_ch(tgt), .rd_img(img)
   );

   mxs_serializer #(.BURST_W(BURST_W), .DIV_W(DIV_W)) i_ser (
      .clk(clk), .rst_n(rst_n), .start(state == ST_ADDR), .load(burst),
      .half(sclk_half), .sclk(ser_sclk), .sdo(ser_sdo), .cs_n(ser_cs_n),
      .done(ser_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tgt       <= '0;
         ret_ch    <= '0;
         pend_ch   <= '0;
         pend_sw   <= 1'b0;
         pend_cal  <= 1'b0;
         cal_mode  <= 1'b0;
         scnt      <= '0;
         sync_n    <= 1'b1;
         mux_addr  <= '0;
         res_valid <= 1'b0;
         res_data  <= '0;
         res_ch    <= '0;
      end else begin
         res_valid <= 1'b0;
         if (sw_req) begin
            pend_sw <= 1'b1;
            pend_ch <= sw_ch;
         end
         if (cal_req) pend_cal <= 1'b1;

         case (state)
            ST_IDLE: begin
               if (pend_cal) begin
                  if (!cal_req) pend_cal <= 1'b0;
                  cal_mode <= 1'b1;
                  ret_ch   <= mux_addr;
                  tgt      <= '0;
                  state    <= ST_SYNC;
               end else if (pend_sw) begin
                  if (!sw_req) pend_sw <= 1'b0;
                  tgt   <= pend_ch;
                  state <= ST_SYNC;
               end
            end
            ST_SYNC: begin
               sync_n <= 1'b0;
               state  <= ST_ADDR;
            end
            ST_ADDR: begin
               mux_addr <= tgt;
               state    <= ST_BURST;
            end
            ST_BURST: begin
               if (ser_done) begin
                  sync_n <= 1'b1;
                  scnt   <= '0;
                  state  <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (adc_drdy) begin
                  if (scnt < SCNT_W'(SETTLE_N)) begin
                     scnt <= scnt + SCNT_W'(1);
                  end else if (!cal_mode) begin
                     res_valid <= 1'b1;
                     res_data  <= adc_data;
                     res_ch    <= mux_addr;
                     state     <= ST_IDLE;
                  end else if (scnt == LAST_CAP) begin
                     if (tgt == CH_W'(N_CH - 1)) begin
                        cal_mode <= 1'b0;
                        tgt      <= ret_ch;
                     end else begin
                        tgt <= tgt + CH_W'(1);
                     end
                     state <= ST_SYNC;
                  end else begin
                     scnt <= scnt + SCNT_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_addr_moves_in_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mux_addr) |-> !sync_n);
   p_burst_inside_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_cs_n |-> !sync_n);
   p_release_after_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_n) |-> $past(ser_done));
   p_result_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   p_result_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy && sync_n);
   p_no_result_in_cal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we |=> !res_valid);
endmodule

// File: tb/test_mux_adc_sequencer.sv
module test_mux_adc_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int DRDY_GAP   = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_req = 1'b0, cal_req = 1'b0, cfg_we = 1'b0;
   logic [1:0]  sw_ch = '0, cfg_ch = '0, cfg_sel = '0;
   logic [23:0] cfg_data = '0;
   logic [7:0]  sclk_half = 8'd8;
   logic        adc_drdy = 1'b0;
   logic [23:0] adc_data = '0;
   logic        sync_n, ser_sclk, ser_sdo, ser_cs_n, busy, res_valid;
   logic [1:0]  mux_addr, res_ch;
   logic [23:0] res_data;

   mux_adc_sequencer i_mux_adc_sequencer (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_ch(sw_ch), .cal_req(cal_req),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .sclk_half(sclk_half), .adc_drdy(adc_drdy), .adc_data(adc_data),
      .sync_n(sync_n), .mux_addr(mux_addr), .ser_sclk(ser_sclk), .ser_sdo(ser_sdo),
      .ser_cs_n(ser_cs_n), .busy(busy), .res_valid(res_valid), .res_data(res_data),
      .res_ch(res_ch)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, n_res = 0, n_res_exp = 0;
   logic [23:0]  m_word [4][4];   // bench copy of the setup images
   logic [127:0] exp_burst_q [$];
   logic [25:0]  exp_res_q [$];
   bit           finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_burst(input int ch);
      return {8'hC0, m_word[ch][0], 8'hC1, m_word[ch][1],
              8'hC2, m_word[ch][2], 8'hC3, m_word[ch][3]};
   endfunction

   function automatic logic [23:0] conv_val(input int ch, input int idx);
      return 24'hA00000 | (24'(ch) << 16) | 24'(idx);
   endfunction

   // converter model: a conversion every DRDY_GAP cycles while out of standby
   int m_tick = 0, m_idx = 0;
   always @(negedge clk) begin
      adc_drdy = 1'b0;
      if (!sync_n || !rst_n) begin
         m_tick = 0;
         m_idx  = 0;
      end else begin
         m_tick++;
         if (m_tick == DRDY_GAP) begin
            m_tick   = 0;
            m_idx++;
            adc_data = conv_val(int'(mux_addr), m_idx);
            adc_drdy = 1'b1;
         end
      end
   end

   // burst monitor
   logic [127:0] cap = '0;
   logic prev_sclk = 1'b1, prev_csn = 1'b1, prev_sdo = 1'b0;
   int cs_len = 0, rises = 0, cyc = 0, last_rise = 0, period = 0;
   bit rise_change = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (ser_cs_n && !ser_sclk) rise_change = 1'b1;
         if (ser_sclk && !prev_sclk && !prev_csn) begin
            cap = {cap[126:0], ser_sdo};
            if (ser_sdo != prev_sdo) rise_change = 1'b1;
            rises++;
            if (rises == 2) period = cyc - last_rise;
            last_rise = cyc;
         end
         if (!ser_cs_n) cs_len++;
         if (!ser_cs_n && prev_csn)   // R2: standby held when burst opens
            chk(sync_n == 1'b0, "R2 sync low at burst start", 128'(sync_n), 128'(0));
         if (ser_cs_n && !prev_csn) begin
            if (exp_burst_q.size() == 0)
               chk(1'b0, "R9 unexpected burst", cap, 128'(0));
            else
               chk(cap == exp_burst_q[0], "R3 R4 burst content", cap, exp_burst_q[0]);
            if (exp_burst_q.size() != 0) void'(exp_burst_q.pop_front());
            chk(cs_len == 256 * int'(sclk_half), "R8 chip select length",
                128'(cs_len), 128'(256 * int'(sclk_half)));
            chk(period == 2 * int'(sclk_half) && !rise_change, "R8 bit period and edges",
                128'(period), 128'(2 * int'(sclk_half)));
            cs_len = 0;
            rises = 0;
            rise_change = 1'b0;
         end
      end
      prev_sclk = ser_sclk;
      prev_csn  = ser_cs_n;
      prev_sdo  = ser_sdo;
   end

   // result monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         n_res++;
         if (exp_res_q.size() == 0) begin
            chk(1'b0, "R10 result while idle", {res_ch, res_data}, 128'(0));
         end else begin
            chk({res_ch, res_data} == exp_res_q[0], "R1 R5 result tag and data",
                {res_ch, res_data}, exp_res_q[0]);
            chk(mux_addr == exp_res_q[0][25:24], "R1 address decode",
                128'(mux_addr), 128'(exp_res_q[0][25:24]));
            chk(busy == 1'b0, "R6 busy low with result", 128'(busy), 128'(0));
            void'(exp_res_q.pop_front());
         end
      end
   end

   task automatic cfg_write(input int ch, input int sel, input logic [23:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = val;
      m_word[ch][sel] = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_switch(input int ch);
      @(negedge clk);
      sw_req = 1'b1; sw_ch = 2'(ch);
      @(negedge clk);
      sw_req = 1'b0;
   endtask

   // driver: push what a switch must produce, then request it
   task automatic do_switch(input int ch);
      exp_burst_q.push_back(exp_burst(ch));
      exp_res_q.push_back({2'(ch), conv_val(ch, 4)});
      n_res_exp++;
      pulse_switch(ch);
   endtask

   task automatic wait_empty();
      while (exp_res_q.size() != 0 || exp_burst_q.size() != 0 || busy) @(negedge clk);
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sync_n == 1'b1 && ser_cs_n == 1'b1, "R2 reset standby released",
          {sync_n, ser_cs_n}, 2'b11);
      chk(ser_sclk == 1'b1, "R8 reset clock idle high", 128'(ser_sclk), 128'(1));
      chk(busy == 1'b0 && res_valid == 1'b0, "R6 reset not busy", {busy, res_valid}, 0);
      rst_n = 1'b1;
      for (int c = 0; c < 4; c++)
         for (int w = 0; w < 4; w++)
            cfg_write(c, w, 24'h100000 + 24'(c * 24'h1111) + 24'(w * 24'h10101));

      // R4 R1: channel 2 with 8-cycle half period
      sclk_half = 8'd8;
      do_switch(2);
      while (sync_n) @(negedge clk);
      chk(busy == 1'b1, "R6 busy during switch", 128'(busy), 128'(1));
      wait_empty();

      // R8: faster serial clock, channel 3
      sclk_half = 8'd2;
      do_switch(3);
      wait_empty();

      // R10: converter keeps running while idle
      repeat (5 * DRDY_GAP) @(negedge clk);
      chk(n_res == n_res_exp, "R10 idle conversions ignored", 128'(n_res), 128'(n_res_exp));

      // R9: newest held request wins
      do_switch(1);
      while (sync_n) @(negedge clk);
      pulse_switch(0);
      exp_burst_q.push_back(exp_burst(3));
      exp_res_q.push_back({2'd3, conv_val(3, 4)});
      n_res_exp++;
      pulse_switch(3);
      wait_empty();
      chk(mux_addr == 2'd3, "R9 held target served", 128'(mux_addr), 128'(3));

      // R7: calibration pass, then return to channel 3
      for (int c = 0; c < 4; c++) begin
         exp_burst_q.push_back(exp_burst(c));
         for (int w = 1; w < 4; w++) m_word[c][w] = conv_val(c, 3 + w);
      end
      exp_burst_q.push_back(exp_burst(3));
      exp_res_q.push_back({2'd3, conv_val(3, 4)});
      n_res_exp++;
      @(negedge clk); cal_req = 1'b1;
      @(negedge clk); cal_req = 1'b0;
      wait_empty();

      // R7 R4: captured coefficients restored on a later switch
      do_switch(0);
      wait_empty();
      repeat (3 * DRDY_GAP) @(negedge clk);
      chk(n_res == n_res_exp, "R5 R10 result count", 128'(n_res), 128'(n_res_exp));
      finished = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
      if (!finished) chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule